// File: doc/BRIEF.md
# Byte-Lane Parity Memory Controller

This controller sits between a requester and a 32-bit memory word. The word is stored in eight 4-bit storage devices, with two devices per byte lane. A ninth 4-bit device holds one even-parity bit for each byte. The requester presents reads and writes over a valid/ready handshake. Writes carry a 4-bit byte-enable mask.

A storage device normally writes all of its bits together. Because of that, a byte write cannot simply write the whole parity device. The controller therefore drives a separate write mask to the parity device, so that only the parity bit of each written lane changes and the other three are kept. On a read, the controller recomputes the parity of all four returned bytes and compares it with the stored bits. It reports a per-lane error vector and a summary error flag in the same cycle as the data.

A four-state machine sequences the work:

| State | Role |
|-------|------|
| ST_IDLE | Ready for a request |
| ST_WRITE | One storage write cycle |
| ST_READ | Storage read issue |
| ST_CHECK | Response with the parity check |

| Transition | From | To | Condition |
|------------|------|----|-----------|
| ACCEPT_WRITE | ST_IDLE | ST_WRITE | Write with a nonzero mask |
| ACCEPT_NOP | ST_IDLE | ST_IDLE | Write with an empty mask |
| ACCEPT_READ | ST_IDLE | ST_READ | Read |
| WRITE_DONE | ST_WRITE | ST_IDLE | Always |
| READ_ISSUED | ST_READ | ST_CHECK | Always |
| RESPOND | ST_CHECK | ST_IDLE | Always |

The storage itself is a synchronous RAM with one cycle of read latency, and it sits outside the block.

Top module: `parity_mem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, and rsp_valid and mem_en are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1, so at most one request is accepted per clock. After an accepted read, or an accepted write with a nonzero mask, req_ready is 0 for the following cycle.
- R3: After a write is accepted with mask 4'b1111, the next cycle has mem_en=1, all eight mem_dev_we bits set and mem_par_wmask=4'b1111. In that cycle mem_addr equals the request address and mem_wdata equals the request data.
- R4: Byte lane k covers data bits 8k+7..8k. Mask bit k enables device-write bits 2k and 2k+1, which cover data bits 8k+3..8k and 8k+7..8k+4, and parity mask bit k. No other enable bits are set.
- R5: Parity is even. For every written lane k, mem_par_wdata[k] is the XOR of data bits 8k+7..8k.
- R6: A write with mask 4'b0000 is a no-op. In the next cycle mem_en is 0 and req_ready is 1, and a later read returns the earlier data with no error.
- R7: An accepted read drives mem_en=1 with all write enables at 0 in the next cycle. rsp_valid rises two cycles after acceptance, and rsp_rdata then carries the stored word.
- R8: While rsp_valid is 1, rsp_perr[k] is 1 exactly when the XOR of returned byte k differs from stored parity bit k. rsp_err is the OR of rsp_perr.
- R9: A byte write leaves the stored parity bits of the unwritten lanes as they were, including any that are already wrong.
- R10: rsp_valid is 1 for exactly one cycle per accepted read and never follows a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_be | input | 4 | Byte-lane write mask |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read data |
| rsp_perr | output | 4 | Per-lane parity mismatch |
| rsp_err | output | 1 | Any lane mismatched |
| mem_addr | output | 8 | Storage address |
| mem_en | output | 1 | Storage access cycle |
| mem_dev_we | output | 8 | Write enable, one per 4-bit data device |
| mem_wdata | output | 32 | Storage write data |
| mem_par_wmask | output | 4 | Per-bit write mask of the parity device |
| mem_par_wdata | output | 4 | Parity bits to store |
| mem_rdata | input | 32 | Storage read data, one cycle after the read |
| mem_par_rdata | input | 4 | Stored parity bits, one cycle after the read |

## Verification
Two functions can meet on the same stored word: a masked byte write and the error detection for a lane that the write does not touch. To provoke this, the bench flips a stored parity bit in its RAM model, then issues a byte write to a different lane of that word, then reads the word back. The scoreboard expects the old error to survive in the untouched lane while the written lane checks clean. A second byte write to the damaged lane must then clear the error.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_CHECK = 2'd3
    } pmc_state_e;

endpackage

// File: rtl/pmc_parity.sv
// Even parity per byte lane: one XOR-reduction per lane.
module pmc_parity #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data,
    output logic [LANES-1:0]        par
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign par[k] = ^data[k*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/pmc_lane_mask.sv
// Expands the byte-lane mask into per-device write enables and the
// per-bit mask of the parity device.
module pmc_lane_mask #(
    parameter int LANES        = 4,
    parameter int DEV_PER_LANE = 2
) (
    input  logic                          en,
    input  logic [LANES-1:0]              be,
    output logic [LANES*DEV_PER_LANE-1:0] dev_we,
    output logic [LANES-1:0]              par_wmask
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        for (genvar j = 0; j < DEV_PER_LANE; j++) begin : g_dev
            assign dev_we[k*DEV_PER_LANE + j] = en & be[k];
        end
        assign par_wmask[k] = en & be[k];
    end

endmodule

// File: rtl/pmc_fsm.sv
// Request sequencer: accepts one request in ST_IDLE and walks it through
// the storage access.
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       be_any,
    output logic       req_ready,
    output logic       accept,
    output pmc_state_e state
);

    pmc_state_e state_q;
    pmc_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write) begin
                        state_d = ST_READ;            // ACCEPT_READ
                    end else if (be_any) begin
                        state_d = ST_WRITE;           // ACCEPT_WRITE
                    end else begin
                        state_d = ST_IDLE;            // ACCEPT_NOP
                    end
                end
            end
            ST_WRITE: state_d = ST_IDLE;              // WRITE_DONE
            ST_READ:  state_d = ST_CHECK;             // READ_ISSUED
            ST_CHECK: state_d = ST_IDLE;              // RESPOND
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        accept    = req_ready & req_valid;
        state     = state_q;
    end

endmodule

// File: rtl/parity_mem_ctrl.sv
module parity_mem_ctrl
    import pmc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int DEV_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_write,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [LANES-1:0]                  req_be,
    input  logic [LANES*LANE_W-1:0]           req_wdata,
    output logic                              rsp_valid,
    output logic [LANES*LANE_W-1:0]           rsp_rdata,
    output logic [LANES-1:0]                  rsp_perr,
    output logic                              rsp_err,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic                              mem_en,
    output logic [LANES*(LANE_W/DEV_W)-1:0]   mem_dev_we,
    output logic [LANES*LANE_W-1:0]           mem_wdata,
    output logic [LANES-1:0]                  mem_par_wmask,
    output logic [LANES-1:0]                  mem_par_wdata,
    input  logic [LANES*LANE_W-1:0]           mem_rdata,
    input  logic [LANES-1:0]                  mem_par_rdata
);

    localparam int DATA_W       = LANES * LANE_W;
    localparam int DEV_PER_LANE = LANE_W / DEV_W;

    pmc_state_e          state;
    logic                accept;
    logic [ADDR_W-1:0]   op_addr;
    logic [LANES-1:0]    op_be;
    logic [DATA_W-1:0]   op_wdata;
    logic [LANES-1:0]    wr_par;
    logic [LANES-1:0]    rd_par;
    logic                wr_phase;
    logic                chk_phase;

    pmc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .be_any    (|req_be),
        .req_ready (req_ready),
        .accept    (accept),
        .state     (state)
    );

    // Captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr  <= '0;
            op_be    <= '0;
            op_wdata <= '0;
        end else if (accept) begin
            op_addr  <= req_addr;
            op_be    <= req_write ? req_be : '0;
            op_wdata <= req_wdata;
        end
    end

    assign wr_phase  = (state == ST_WRITE);
    assign chk_phase = (state == ST_CHECK);

    pmc_lane_mask #(
        .LANES        (LANES),
        .DEV_PER_LANE (DEV_PER_LANE)
    ) u_mask (
        .en        (wr_phase),
        .be        (op_be),
        .dev_we    (mem_dev_we),
        .par_wmask (mem_par_wmask)
    );

    pmc_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_wpar (
        .data (op_wdata),
        .par  (wr_par)
    );

    pmc_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_rpar (
        .data (mem_rdata),
        .par  (rd_par)
    );

    // Storage side
    assign mem_addr      = op_addr;
    assign mem_en        = wr_phase | (state == ST_READ);
    assign mem_wdata     = op_wdata;
    assign mem_par_wdata = wr_par;

    // Response side: data and check result share the cycle
    assign rsp_valid = chk_phase;
    assign rsp_rdata = chk_phase ? mem_rdata : '0;
    assign rsp_perr  = chk_phase ? (rd_par ^ mem_par_rdata) : '0;
    assign rsp_err   = |rsp_perr;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int LANES = 4,
    parameter int NDEV  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [LANES-1:0] req_be,
    input logic             rsp_valid,
    input logic             mem_en,
    input logic [NDEV-1:0]  mem_dev_we
);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (!req_write || req_be != '0)) |=> !req_ready);

    // R6
    empty_mask_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && req_be == '0) |=> (!mem_en && req_ready));

    // R7
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |-> ##2 rsp_valid);

    // R10
    resp_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_en && (mem_dev_we == '0)));

    // R3
    write_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dev_we != '0) |-> $past(req_valid && req_ready && req_write));

endmodule

bind parity_mem_ctrl pmc_checker #(
    .LANES (LANES),
    .NDEV  (LANES*(LANE_W/DEV_W))
) u_pmc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_be     (req_be),
    .rsp_valid  (rsp_valid),
    .mem_en     (mem_en),
    .mem_dev_we (mem_dev_we)
);

// File: tb/parity_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module parity_mem_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  rsp_perr;
    logic        rsp_err;
    logic [7:0]  mem_addr;
    logic        mem_en;
    logic [7:0]  mem_dev_we;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_par_wmask;
    logic [3:0]  mem_par_wdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_par_rdata = '0;

    always #2 clk = ~clk;

    parity_mem_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
        .rsp_err(rsp_err), .mem_addr(mem_addr), .mem_en(mem_en),
        .mem_dev_we(mem_dev_we), .mem_wdata(mem_wdata),
        .mem_par_wmask(mem_par_wmask), .mem_par_wdata(mem_par_wdata),
        .mem_rdata(mem_rdata), .mem_par_rdata(mem_par_rdata)
    );

    // Storage model with fault injection
    logic [31:0] ram_d [256];
    logic [3:0]  ram_p [256];
    logic        inj_valid = 1'b0;
    logic [7:0]  inj_addr = '0;
    logic [31:0] inj_dflip = '0;
    logic [3:0]  inj_pflip = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram_d[i] = '0;
            ram_p[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (inj_valid) begin
            ram_d[inj_addr] <= ram_d[inj_addr] ^ inj_dflip;
            ram_p[inj_addr] <= ram_p[inj_addr] ^ inj_pflip;
        end else if (mem_en) begin
            for (int d = 0; d < 8; d++)
                if (mem_dev_we[d]) ram_d[mem_addr][4*d +: 4] <= mem_wdata[4*d +: 4];
            for (int k = 0; k < 4; k++)
                if (mem_par_wmask[k]) ram_p[mem_addr][k] <= mem_par_wdata[k];
            mem_rdata     <= ram_d[mem_addr];
            mem_par_rdata <= ram_p[mem_addr];
        end
    end

    // Bench shadow of the expected storage contents
    logic [31:0] sh_d [256];
    logic [3:0]  sh_p [256];
    initial begin
        for (int i = 0; i < 256; i++) begin
            sh_d[i] = '0;
            sh_p[i] = '0;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  perr;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    function automatic logic [3:0] byte_par(logic [31:0] d);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ^d[8*k +: 8];
        return p;
    endfunction

    function automatic logic [7:0] we_of(logic [3:0] be);
        logic [7:0] w;
        for (int k = 0; k < 4; k++) begin
            w[2*k]   = be[k];
            w[2*k+1] = be[k];
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Driver: one request, checks of the storage-side cycle that follows
    task automatic do_req(input bit wr, input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr && be == 4'b0000) begin
            // R6
            chk(!mem_en, "R6", "mem_en on empty mask", {31'b0, mem_en}, 32'h0);
            chk(req_ready, "R6", "ready after empty mask", {31'b0, req_ready}, 32'h1);
        end else if (wr) begin
            logic [3:0] ep;
            ep = byte_par(d);
            chk(!req_ready, "R2", "ready during write", {31'b0, req_ready}, 32'h0);
            chk(mem_en && mem_addr == a && mem_wdata == d, tag, "write addr/data",
                {mem_addr, mem_wdata[23:0]}, {a, d[23:0]});
            // R4 lane to device mapping
            chk(mem_dev_we == we_of(be) && mem_par_wmask == be, "R4", "enables",
                {16'b0, mem_dev_we, 4'b0, mem_par_wmask}, {16'b0, we_of(be), 4'b0, be});
            // R5 even parity
            chk((mem_par_wdata & be) == (ep & be), "R5", "parity bits",
                {28'b0, mem_par_wdata & be}, {28'b0, ep & be});
            for (int k = 0; k < 4; k++) begin
                if (be[k]) begin
                    sh_d[a][8*k +: 8] = d[8*k +: 8];
                    sh_p[a][k] = ep[k];
                end
            end
        end else begin
            // R7
            chk(mem_en && mem_dev_we == 8'h0 && mem_addr == a, "R7", "read issue",
                {23'b0, mem_en, mem_dev_we}, {23'b0, 1'b1, 8'h0});
            chk(!req_ready, "R2", "ready during read", {31'b0, req_ready}, 32'h0);
            exp_q.push_back('{d: sh_d[a], perr: byte_par(sh_d[a]) ^ sh_p[a], tag: tag});
        end
    endtask

    task automatic inject(input logic [7:0] a, input logic [31:0] df, input logic [3:0] pf);
        @(negedge clk);
        inj_valid = 1'b1; inj_addr = a; inj_dflip = df; inj_pflip = pf;
        @(posedge clk);
        @(negedge clk);
        inj_valid = 1'b0;
        sh_d[a] = sh_d[a] ^ df;
        sh_p[a] = sh_p[a] ^ pf;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected response", rsp_rdata, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e.d, e.tag, "read data", rsp_rdata, e.d);
                chk(rsp_perr == e.perr, e.tag, "perr (R8)", {28'b0, rsp_perr}, {28'b0, e.perr});
                chk(rsp_err == (e.perr != 0), e.tag, "err flag (R8)",
                    {31'b0, rsp_err}, {31'b0, e.perr != 0});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(req_ready && !rsp_valid && !mem_en, "R1", "reset state",
            {29'b0, req_ready, rsp_valid, mem_en}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_en, "R1", "after reset",
            {29'b0, req_ready, rsp_valid, mem_en}, 32'h4);

        // R3 full word write and read back
        do_req(1'b1, 8'd3, 4'hF, 32'hA5C3_0F81, "R3");
        do_req(1'b0, 8'd3, 4'h0, 32'h0, "R3");
        do_req(1'b1, 8'd4, 4'hF, 32'h0102_0408, "R5");
        do_req(1'b0, 8'd4, 4'h0, 32'h0, "R5");

        // R4 single-lane writes build up a word
        do_req(1'b1, 8'd10, 4'b0001, 32'hDEAD_BE11, "R4");
        do_req(1'b1, 8'd10, 4'b0100, 32'h1237_5678, "R4");
        do_req(1'b1, 8'd10, 4'b1000, 32'hFE00_0000, "R4");
        do_req(1'b1, 8'd10, 4'b0010, 32'h0000_7F00, "R4");
        do_req(1'b0, 8'd10, 4'h0, 32'h0, "R4");
        do_req(1'b1, 8'd11, 4'b1010, 32'h8001_FF03, "R4");
        do_req(1'b0, 8'd11, 4'h0, 32'h0, "R4");

        // R6 empty mask leaves contents alone
        do_req(1'b1, 8'd3, 4'b0000, 32'hFFFF_FFFF, "R6");
        do_req(1'b0, 8'd3, 4'h0, 32'h0, "R6");

        // R8 detected errors: parity bit and data bit
        inject(8'd10, 32'h0, 4'b0100);
        do_req(1'b0, 8'd10, 4'h0, 32'h0, "R8");
        inject(8'd3, 32'h0000_0001, 4'b0000);
        do_req(1'b0, 8'd3, 4'h0, 32'h0, "R8");
        inject(8'd4, 32'h0100_0010, 4'b0000);
        do_req(1'b0, 8'd4, 4'h0, 32'h0, "R8");

        // R9 byte write next to a bad lane keeps the bad parity
        do_req(1'b1, 8'd20, 4'hF, 32'h1122_3344, "R9");
        inject(8'd20, 32'h0, 4'b0010);
        do_req(1'b1, 8'd20, 4'b1000, 32'h9900_0000, "R9");
        do_req(1'b0, 8'd20, 4'h0, 32'h0, "R9");
        do_req(1'b1, 8'd20, 4'b0010, 32'h0000_5500, "R9");
        do_req(1'b0, 8'd20, 4'h0, 32'h0, "R9");

        // R10 back-to-back reads give one response each
        for (int i = 0; i < 4; i++) do_req(1'b0, 8'(10 + i), 4'h0, 32'h0, "R10");

        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "responses outstanding", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule